// File: doc/BRIEF.md
# Host-Write Instruction Controller for a Parallel MAC Array

This block sits between a host's memory-style write port and an array of multiply-accumulate processing elements. The host selects the chip, raises write and presents a 16-bit address and a 16-bit data word. The low four address bits name one of nine instructions. The data word is the instruction's operand. The controller turns each accepted write into a one-cycle control strobe for the array. It also latches the operands the array needs and keeps the weight-memory address pointer that all processing elements share.

The controller recognises nine instructions:

- set the output scaling window
- select the output processing element
- write the weight memory
- load the pointer
- load the result register
- clear the accumulators
- advance the pointer
- calculate
- calculate and then advance the pointer

A calculate broadcasts the latched data word to every processing element at once. The fused instruction lets the host walk a weight row with a single write per step. Its MAC reads the weight at the current pointer, and the pointer moves on one cycle later.

Top module: `ictl_top`

## Requirements
- R1: An instruction is accepted on a rising clock edge only when both `sel` and `wr` are high. Without acceptance, no strobe is raised and the pointer and operands do not change (apart from a fused-advance step still pending from the previous edge).
- R2: The opcode is `addr[3:0]` and `addr[15:4]` is ignored. The opcodes are 0 set window, 1 select element, 2 weight write, 3 pointer load, 4 result load, 5 accumulator clear, 6 pointer advance, 7 calculate, 8 calculate-then-advance. An accepted opcode k raises `ctl_stb[k]` alone, for exactly the one cycle after the accepting edge.
- R3: Opcodes 9 to 15 raise no strobe and leave the pointer, `op_data`, `win_val` and `nsel_val` unchanged.
- R4: Opcode 3 loads `wptr` from `din[7:0]`, visible right after the accepting edge.
- R5: Opcode 6 adds one to `wptr` at the accepting edge, wrapping from 255 to 0.
- R6: Opcode 8 raises `ctl_stb[8]` and `mac_go` while `wptr` still holds the pre-increment address. `wptr` advances by one at the following edge.
- R7: `mac_go` is high for the one cycle after an accepted opcode 7 or 8. `op_data` then holds the `din` word of that write. `op_data` is updated by every accepted opcode 0 to 8.
- R8: Opcode 0 latches `din[4:0]` into `win_val`. Opcode 1 latches `din[4:0]` into `nsel_val`. Both hold their values otherwise.
- R9: The pending advance from an opcode 8 can meet an instruction accepted on the next edge. If that instruction is a pointer load, the loaded value wins. If it is a pointer advance, the pointer moves by two in total.
- R10: A synchronous active-low reset clears `wptr`, all strobes, `mac_go`, `op_data`, `win_val`, `nsel_val` and any pending advance, even while a write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Host chip select |
| wr | input | 1 | Host write enable |
| addr | input | 16 | Host address; bits 3:0 carry the opcode |
| din | input | 16 | Host data; the instruction operand |
| ctl_stb | output | 9 | One-hot single-cycle strobes, indexed by opcode |
| mac_go | output | 1 | MAC enable for calculate and fused calculate |
| wptr | output | 8 | Shared weight-memory address pointer |
| op_data | output | 16 | Operand of the last accepted instruction |
| win_val | output | 5 | Scaling window setting |
| nsel_val | output | 5 | Selected output processing element |

## Verification
The hardest situation to reach is an instruction that lands on the same edge as the delayed pointer step left by a fused calculate. In that case the load-over-step priority and the double advance decide the pointer value. The stimulus table drives a fused calculate and then, on the very next cycle, a pointer load. It repeats this with a plain advance and then with a second fused calculate. After each row it compares the pointer against a value worked out by hand, including the 255-to-0 wrap reached by loading 0xFE and advancing twice.

// File: rtl/ictl_pkg.sv
// Package: shared opcode encoding and sizes for the instruction controller.
// Assumes the opcode field is four bits wide and the nine opcodes are dense from 0.
package ictl_pkg;
    localparam int NUM_OPS = 9;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SETWIN  = 4'd0,
        OP_SELPE   = 4'd1,
        OP_WWRITE  = 4'd2,
        OP_PTRLD   = 4'd3,
        OP_RESLD   = 4'd4,
        OP_ACCCLR  = 4'd5,
        OP_PTRINC  = 4'd6,
        OP_CALC    = 4'd7,
        OP_CALCINC = 4'd8
    } ictl_op_e;
endpackage

// File: rtl/ictl_decode.sv
// Module: combinational opcode decoder.
// Turns a qualified host write into a one-hot hit vector, one bit per opcode.
// Assumes: opcodes at or above NUM_OPS decode to no hit.
module ictl_decode
    import ictl_pkg::*;
#(
    parameter int N_OPS = NUM_OPS
) (
    input  logic            sel,
    input  logic            wr,
    input  logic [OP_W-1:0] opc,
    output logic            accept,
    output logic [N_OPS-1:0] hit
);
    // The host write is qualified by both select and write.
    assign accept = sel & wr;

    // One comparator per opcode; out-of-range codes match none.
    for (genvar k = 0; k < N_OPS; k++) begin : g_hit
        assign hit[k] = accept && (opc == OP_W'(k));
    end
endmodule

// File: rtl/ictl_strobe.sv
// Module: strobe register stage.
// Registers the decoded hits into single-cycle strobes and derives the MAC enable.
// Assumes: the hit vector is one-hot or zero, so the strobes stay so.
module ictl_strobe
    import ictl_pkg::*;
#(
    parameter int N_OPS = NUM_OPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OPS-1:0] hit,
    output logic [N_OPS-1:0] stb,
    output logic             mac_go
);
    logic mac_hit;

    // A calculate of either form enables the MAC units.
    assign mac_hit = hit[OP_CALC] | hit[OP_CALCINC];

    // Each hit becomes a strobe lasting one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb    <= '0;
            mac_go <= 1'b0;
        end else begin
            stb    <= hit;
            mac_go <= mac_hit;
        end
    end
endmodule

// File: rtl/ictl_ptr.sv
// Module: shared weight-memory address pointer.
// It loads, advances, and delays by one cycle the advance that belongs to a fused calculate.
// Assumes: ld, inc and fuse are mutually exclusive within one cycle.
module ictl_ptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             inc,
    input  logic             fuse,
    output logic [PTR_W-1:0] ptr
);
    logic             pend;
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] nxt;

    // Fold in the step left over from last cycle's fused calculate.
    always_comb begin
        base = pend ? ptr + PTR_W'(1) : ptr;
        if (ld)
            nxt = ld_val;
        else if (inc)
            nxt = base + PTR_W'(1);
        else
            nxt = base;
    end

    // Pointer and pending-step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            pend <= 1'b0;
        end else begin
            ptr  <= nxt;
            pend <= fuse;
        end
    end
endmodule

// File: rtl/ictl_operands.sv
// Module: operand latches.
// Holds the last accepted data word, the scaling window and the selected element.
// Assumes: valid_any is high only for an accepted opcode within range.
module ictl_operands #(
    parameter int DATA_W = 16,
    parameter int WIN_W  = 5,
    parameter int NSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_any,
    input  logic              set_win,
    input  logic              set_nsel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] op_data,
    output logic [WIN_W-1:0]  win_val,
    output logic [NSEL_W-1:0] nsel_val
);
    // The broadcast data word follows every valid instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_data <= '0;
        else if (valid_any)
            op_data <= din;
    end

    // Window and element selection change only on their own opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_val  <= '0;
            nsel_val <= '0;
        end else begin
            if (set_win)
                win_val <= din[WIN_W-1:0];
            if (set_nsel)
                nsel_val <= din[NSEL_W-1:0];
        end
    end
endmodule

// File: rtl/ictl_top.sv
// Module: instruction controller top.
// Decodes host writes, drives the MAC-array strobes, and keeps the pointer and operands.
// Assumes: one instruction at most per clock, sampled on the rising edge.
module ictl_top
    import ictl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8,
    parameter int WIN_W  = 5,
    parameter int NSEL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  din,
    output logic [NUM_OPS-1:0] ctl_stb,
    output logic               mac_go,
    output logic [PTR_W-1:0]   wptr,
    output logic [DATA_W-1:0]  op_data,
    output logic [WIN_W-1:0]   win_val,
    output logic [NSEL_W-1:0]  nsel_val
);
    logic               accept;
    logic [NUM_OPS-1:0] hit;
    logic               valid_any;

    ictl_decode #(.N_OPS(NUM_OPS)) u_dec (
        .sel    (sel),
        .wr     (wr),
        .opc    (addr[OP_W-1:0]),
        .accept (accept),
        .hit    (hit)
    );

    // Any in-range opcode counts as a valid instruction.
    assign valid_any = |hit;

    ictl_strobe #(.N_OPS(NUM_OPS)) u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .stb    (ctl_stb),
        .mac_go (mac_go)
    );

    ictl_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (hit[OP_PTRLD]),
        .ld_val (din[PTR_W-1:0]),
        .inc    (hit[OP_PTRINC]),
        .fuse   (hit[OP_CALCINC]),
        .ptr    (wptr)
    );

    ictl_operands #(.DATA_W(DATA_W), .WIN_W(WIN_W), .NSEL_W(NSEL_W)) u_opr (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_any (valid_any),
        .set_win   (hit[OP_SETWIN]),
        .set_nsel  (hit[OP_SELPE]),
        .din       (din),
        .op_data   (op_data),
        .win_val   (win_val),
        .nsel_val  (nsel_val)
    );
endmodule

// File: rtl/ictl_chk.sv
// Module: property checker for ictl_top, attached with a bind.
module ictl_chk
    import ictl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel,
    input logic               wr,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  din,
    input logic [NUM_OPS-1:0] ctl_stb,
    input logic               mac_go,
    input logic [PTR_W-1:0]   wptr,
    input logic [DATA_W-1:0]  op_data
);
    logic            acc;
    logic [OP_W-1:0] opc;
    logic            prev_ci;

    assign acc = sel & wr;
    assign opc = addr[OP_W-1:0];

    // Remembers that a fused calculate was accepted on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_ci <= 1'b0;
        else
            prev_ci <= acc && (opc == OP_CALCINC);
    end

    assert_no_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (ctl_stb == '0));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_stb));

    assert_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc >= OP_W'(NUM_OPS)) |=> (ctl_stb == '0 && $stable(op_data)));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc == OP_PTRLD) |=> (wptr == $past(din[PTR_W-1:0])));

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc == OP_PTRINC && !prev_ci) |=> (wptr == PTR_W'($past(wptr) + PTR_W'(1))));

    assert_fuse_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opc == OP_CALCINC && !prev_ci) |=> (ctl_stb[OP_CALCINC] && mac_go && $stable(wptr)));

    assert_fuse_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_stb[OP_CALCINC] && !(acc && (opc == OP_PTRLD || opc == OP_PTRINC)))
        |=> (wptr == PTR_W'($past(wptr) + PTR_W'(1))));

    assert_mac_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (opc == OP_CALC || opc == OP_CALCINC)) |=> (mac_go && op_data == $past(din)));
endmodule

bind ictl_top ictl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr      (wr),
    .addr    (addr),
    .din     (din),
    .ctl_stb (ctl_stb),
    .mac_go  (mac_go),
    .wptr    (wptr),
    .op_data (op_data)
);

// File: tb/sim_ictl_top.sv
// Bench for ictl_top: a table of host writes with expected strobes and pointer, then directed reset tests.
module sim_ictl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] din = '0;
    logic [8:0]  ctl_stb;
    logic        mac_go;
    logic [7:0]  wptr;
    logic [15:0] op_data;
    logic [4:0]  win_val;
    logic [4:0]  nsel_val;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ictl_top u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .din(din),
        .ctl_stb(ctl_stb), .mac_go(mac_go), .wptr(wptr), .op_data(op_data),
        .win_val(win_val), .nsel_val(nsel_val)
    );

    // Row layout: sel, wr, addr, din, expected strobes, expected pointer.
    localparam int NV = 23;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'h0006, 16'h0000, 9'h000, 8'h00},  // R1 no select
        {1'b1, 1'b0, 16'h0006, 16'h0000, 9'h000, 8'h00},  // R1 no write
        {1'b1, 1'b1, 16'h0003, 16'h00FE, 9'h008, 8'hFE},  // R4 load
        {1'b1, 1'b1, 16'h0006, 16'h0000, 9'h040, 8'hFF},  // R5 advance
        {1'b1, 1'b1, 16'h0006, 16'h0000, 9'h040, 8'h00},  // R5 wrap
        {1'b1, 1'b1, 16'h0003, 16'h1234, 9'h008, 8'h34},  // R4 load low byte
        {1'b1, 1'b1, 16'h0008, 16'h0055, 9'h100, 8'h34},  // R6 fused, old address
        {1'b0, 1'b0, 16'h0000, 16'h0000, 9'h000, 8'h35},  // R6 step lands
        {1'b1, 1'b1, 16'hFFF7, 16'hABCD, 9'h080, 8'h35},  // R2 upper bits ignored, R7
        {1'b1, 1'b1, 16'h0009, 16'h1111, 9'h000, 8'h35},  // R3
        {1'b1, 1'b1, 16'h000F, 16'hFFFF, 9'h000, 8'h35},  // R3
        {1'b1, 1'b1, 16'h0000, 16'h0013, 9'h001, 8'h35},  // R8 window
        {1'b1, 1'b1, 16'h0001, 16'h003F, 9'h002, 8'h35},  // R8 element
        {1'b1, 1'b1, 16'h0002, 16'h0A0B, 9'h004, 8'h35},  // R2
        {1'b1, 1'b1, 16'h0004, 16'h0000, 9'h010, 8'h35},  // R2
        {1'b1, 1'b1, 16'h0005, 16'h0000, 9'h020, 8'h35},  // R2
        {1'b1, 1'b1, 16'h0008, 16'h0001, 9'h100, 8'h35},  // R6
        {1'b1, 1'b1, 16'h0003, 16'h0010, 9'h008, 8'h10},  // R9 load wins
        {1'b1, 1'b1, 16'h0008, 16'h0002, 9'h100, 8'h10},  // R6
        {1'b1, 1'b1, 16'h0006, 16'h0000, 9'h040, 8'h12},  // R9 double step
        {1'b1, 1'b1, 16'h0008, 16'h0003, 9'h100, 8'h12},  // R6
        {1'b1, 1'b1, 16'h0008, 16'h0004, 9'h100, 8'h13},  // R9 fused after fused
        {1'b0, 1'b0, 16'h0000, 16'h0000, 9'h000, 8'h14}   // R6
    };

    // Counts one check and reports a mismatch.
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset(input string req);
        chk(req, "strobes", 32'(ctl_stb), 32'h0);
        chk(req, "mac_go", 32'(mac_go), 32'h0);
        chk(req, "pointer", 32'(wptr), 32'h0);
        chk(req, "op_data", 32'(op_data), 32'h0);
        chk(req, "window", 32'(win_val), 32'h0);
        chk(req, "element", 32'(nsel_val), 32'h0);
    endtask

    initial begin
        logic [15:0] m_data = '0;
        logic [4:0]  m_win = '0;
        logic [4:0]  m_nsel = '0;
        repeat (3) @(negedge clk);
        check_reset("R10");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            logic [8:0]  es;
            v = VEC[i];
            es = v[16:8];
            sel = v[50];
            wr = v[49];
            addr = v[48:33];
            din = v[32:17];
            if (v[50] && v[49] && v[36:33] <= 4'd8) m_data = v[32:17];
            if (v[50] && v[49] && v[36:33] == 4'd0) m_win = v[21:17];
            if (v[50] && v[49] && v[36:33] == 4'd1) m_nsel = v[21:17];
            @(negedge clk);
            chk("R2", "strobes", 32'(ctl_stb), 32'(es));
            chk("R9", "pointer", 32'(wptr), 32'(v[7:0]));
            chk("R7", "mac_go", 32'(mac_go), 32'(es[7] | es[8]));
            chk("R3", "op_data", 32'(op_data), 32'(m_data));
            chk("R8", "window", 32'(win_val), 32'(m_win));
            chk("R8", "element", 32'(nsel_val), 32'(m_nsel));
        end

        // R10: a reset asserted while a pointer load is presented clears everything.
        sel = 1'b1; wr = 1'b1; addr = 16'h0003; din = 16'h0077;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R10");
        sel = 1'b0; wr = 1'b0;
        rst_n = 1'b1;

        // R10: a fused step pending at reset is dropped.
        sel = 1'b1; wr = 1'b1; addr = 16'h0008; din = 16'h0009;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "pointer after pending step", 32'(wptr), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule